// File: doc/BRIEF.md
# CPU Clock Power Mode Controller

This block picks the source and division ratio of the CPU clock in a small microcontroller-style system. It also enforces the rules for entering and leaving a low-power state in which the fast oscillator is stopped. Both oscillators are seen as tick pulses (clock enables) in one reference clock domain. The CPU clock is therefore a one-cycle enable pulse, `cpu_en`, and every switch of source or ratio can be observed cycle by cycle.

Software-style single-cycle write strobes request a new operating mode, a new medium-speed division ratio, or a change to the slow oscillator enable. A mode request is held pending until its target oscillator reports stable. It is then applied only at the end of a complete CPU clock period. Entering the low-power state forces the division ratio to divide-by-8 and freezes it. Because of this, the first return to the fast clock always runs at medium speed, divide-by-8. A separate output gives one count enable every 32 slow ticks for timers.

Top module: `cpuclk_pwr_ctrl`

## Requirements
- R1: After reset the block is in medium-speed mode with divider code 10 (divide-by-8). The fast oscillator is marked on, the slow oscillator enable is 0, and there is no pending request and no error.
- R2: In high-speed mode (mode code 00), `cpu_en` pulses on every `main_tick`.
- R3: In medium-speed mode (mode code 01), `cpu_en` pulses once per 2^(c+1) `main_tick` pulses, where c is the divider code: 00=/2, 01=/4, 10=/8, 11=/16.
- R4: A new divider code or CPU clock source takes effect only at a CPU clock boundary. A period that has already started always runs to its full old length.
- R5: In low-speed mode (mode code 10), `cpu_en` follows `sub_tick` and `per_en` keeps following `main_tick`.
- R6: A switch to a fast-clock mode requires `main_stable`. A switch to low-speed requires `sub_stable` and the slow enable, plus `main_stable` when leaving low-power. Until those hold, `req_pend` stays 1 and the current mode is kept.
- R7: A request for low-power mode (mode code 11) is accepted only while in low-speed mode. In any other mode the request is dropped and `err_stat` is set, and it stays set until reset.
- R8: Entering low-power mode clears `main_on`, stops `per_en`, and sets the divider code to 10 on the same clock edge as the mode change.
- R9: While in low-power mode, divider writes are ignored. A request for high- or medium-speed from low-power lands in medium-speed with divide-by-8.
- R10: `tmr_en` pulses once every 32 `sub_tick` pulses while the slow enable is 1 and never while it is 0. Clearing the slow enable is ignored in low-speed and low-power modes.
- R11: `mode_stat` reports the current mode as 00 high-speed, 01 medium-speed, 10 low-speed, 11 low-power.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One pulse per fast oscillator period |
| sub_tick | input | 1 | One pulse per slow oscillator period |
| main_stable | input | 1 | Fast oscillator is stable |
| sub_stable | input | 1 | Slow oscillator is stable |
| mode_wr | input | 1 | Mode request write strobe |
| mode_req | input | 2 | Requested mode code |
| div_wr | input | 1 | Divider write strobe |
| div_val | input | 2 | Divider code for medium-speed |
| sube_wr | input | 1 | Slow oscillator enable write strobe |
| sube_val | input | 1 | Slow oscillator enable value |
| cpu_en | output | 1 | CPU clock enable pulse |
| cpu_src | output | 1 | CPU clock source, 1 = slow oscillator |
| per_en | output | 1 | Peripheral clock enable pulse |
| tmr_en | output | 1 | Slow count source for timers (slow / 32) |
| mode_stat | output | 2 | Current mode code |
| div_stat | output | 2 | Divider code in effect |
| main_on | output | 1 | Fast oscillator is running |
| sub_on | output | 1 | Slow oscillator enable |
| req_pend | output | 1 | A mode request is waiting |
| err_stat | output | 1 | Sticky illegal low-power request flag |

## Verification
On every cycle, the assertions check the following:
- low-power is entered only from low-speed;
- the divider code is 10 and does not move while low-power lasts;
- a mode change happens only after a CPU clock boundary;
- a change into a fast mode happens only while the fast oscillator is stable;
- the error flag never clears;
- the divide counter never passes its limit;
- the timer source never pulses with the slow oscillator off.

The actual pulse spacings for each divider code and tick rate can only be shown by the bench's scenarios. The same holds for the full old period running out before a ratio change, for a request that stays pending under an unstable oscillator, and for the landing at divide-by-8 after low-power.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;
   typedef enum logic [1:0] {
      MD_HIGH = 2'b00,
      MD_MED  = 2'b01,
      MD_LOW  = 2'b10,
      MD_LPD  = 2'b11
   } pmode_t;
endpackage

// File: rtl/cpuclk_divider.sv
module cpuclk_divider
   import cpuclk_pkg::*;
#(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_tick,
   input  logic             sub_tick,
   input  pmode_t           mode,
   input  logic [DIV_W-1:0] div,
   output logic             cpu_en,
   output logic             cpu_src,
   output logic             per_en
);
   localparam int CNT_W = 1 << DIV_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;
   logic [CNT_W:0]   ratio;
   logic             on_main;

   always_comb begin
      on_main = (mode == MD_HIGH) || (mode == MD_MED);
      ratio   = (CNT_W+1)'(1) << ({1'b0, div} + 1'b1);
      lim     = (mode == MD_HIGH) ? '0 : CNT_W'(ratio - 1'b1);
      cpu_en  = on_main ? (main_tick && (cnt_q == lim)) : sub_tick;
      per_en  = main_tick && (mode != MD_LPD);
      cpu_src = !on_main;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (!on_main || cpu_en) cnt_q <= '0;
      else if (main_tick)          cnt_q <= cnt_q + 1'b1;
   end

   // R4
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      on_main |-> (cnt_q <= lim));
endmodule

// File: rtl/cpuclk_mode_fsm.sv
module cpuclk_mode_fsm
   import cpuclk_pkg::*;
#(
   parameter int DIV_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd,
   input  logic             main_stable,
   input  logic             sub_stable,
   input  logic             mode_wr,
   input  logic [1:0]       mode_req,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_val,
   input  logic             sube_wr,
   input  logic             sube_val,
   output pmode_t           mode,
   output logic [DIV_W-1:0] div,
   output logic             sub_on,
   output logic             pend,
   output logic             err
);
   localparam logic [DIV_W-1:0] DIV8 = DIV_W'(2);

   pmode_t           mode_q, pend_m_q, tgt;
   logic             pend_v_q, err_q, sub_on_q, tgt_ok, commit, on_sub;
   logic [DIV_W-1:0] div_q, div_nx_q;

   always_comb begin
      on_sub = (mode_q == MD_LOW) || (mode_q == MD_LPD);
      tgt    = pend_m_q;
      if (mode_q == MD_LPD && (pend_m_q == MD_HIGH || pend_m_q == MD_MED))
         tgt = MD_MED;
      case (tgt)
         MD_HIGH, MD_MED: tgt_ok = main_stable;
         MD_LOW:          tgt_ok = sub_stable && sub_on_q &&
                                   (mode_q != MD_LPD || main_stable);
         default:         tgt_ok = (mode_q == MD_LOW);
      endcase
      commit = bnd && pend_v_q && tgt_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MD_MED;
         pend_m_q <= MD_MED;
         pend_v_q <= 1'b0;
         err_q    <= 1'b0;
         sub_on_q <= 1'b0;
         div_q    <= DIV8;
         div_nx_q <= DIV8;
      end else begin
         if (commit) begin
            mode_q   <= tgt;
            pend_v_q <= 1'b0;
         end
         if (mode_wr) begin
            if (pmode_t'(mode_req) == MD_LPD && mode_q != MD_LOW) begin
               err_q <= 1'b1;
            end else begin
               pend_v_q <= 1'b1;
               pend_m_q <= pmode_t'(mode_req);
            end
         end
         if (div_wr && mode_q != MD_LPD) div_nx_q <= div_val;
         if (bnd && mode_q != MD_LPD)    div_q    <= div_nx_q;
         if (commit && tgt == MD_LPD) begin
            div_q    <= DIV8;
            div_nx_q <= DIV8;
         end
         if (sube_wr && (sube_val || !on_sub)) sub_on_q <= sube_val;
      end
   end

   assign mode   = mode_q;
   assign div    = div_q;
   assign sub_on = sub_on_q;
   assign pend   = pend_v_q;
   assign err    = err_q;

   // R7
   lpd_from_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_LPD && $past(mode_q) != MD_LPD) |-> ($past(mode_q) == MD_LOW));
   // R8
   lpd_div8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_LPD) |-> (div_q == DIV8));
   // R9
   lpd_div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_LPD && $past(mode_q) == MD_LPD) |-> $stable(div_q));
   // R4
   switch_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q)) |-> $past(bnd));
   // R6
   main_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != $past(mode_q) && (mode_q == MD_HIGH || mode_q == MD_MED))
      |-> $past(main_stable));
   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
endmodule

// File: rtl/cpuclk_tmr_src.sv
module cpuclk_tmr_src #(
   parameter int TMR_DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sub_tick,
   input  logic sub_on,
   output logic tmr_en
);
   generate
      if (TMR_DIV == 1) begin : g_pass
         assign tmr_en = sub_tick && sub_on;
      end else begin : g_cnt
         localparam int TW = $clog2(TMR_DIV);
         localparam logic [TW-1:0] LAST = TW'(TMR_DIV - 1);
         logic [TW-1:0] tcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        tcnt_q <= '0;
            else if (!sub_on)  tcnt_q <= '0;
            else if (sub_tick) tcnt_q <= (tcnt_q == LAST) ? '0 : tcnt_q + 1'b1;
         end
         assign tmr_en = sub_on && sub_tick && (tcnt_q == LAST);
      end
   endgenerate

   // R10
   tmr_needs_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_en |-> sub_on);
endmodule

// File: rtl/cpuclk_pwr_ctrl.sv
module cpuclk_pwr_ctrl
   import cpuclk_pkg::*;
#(
   parameter int DIV_W   = 2,
   parameter int TMR_DIV = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             main_tick,
   input  logic             sub_tick,
   input  logic             main_stable,
   input  logic             sub_stable,
   input  logic             mode_wr,
   input  logic [1:0]       mode_req,
   input  logic             div_wr,
   input  logic [DIV_W-1:0] div_val,
   input  logic             sube_wr,
   input  logic             sube_val,
   output logic             cpu_en,
   output logic             cpu_src,
   output logic             per_en,
   output logic             tmr_en,
   output logic [1:0]       mode_stat,
   output logic [DIV_W-1:0] div_stat,
   output logic             main_on,
   output logic             sub_on,
   output logic             req_pend,
   output logic             err_stat
);
   generate
      if (DIV_W < 2 || DIV_W > 3) begin : g_bad_div
         $error("DIV_W must be 2 or 3");
      end
      if (TMR_DIV < 1 || (TMR_DIV & (TMR_DIV - 1)) != 0) begin : g_bad_tmr
         $error("TMR_DIV must be a power of two");
      end
   endgenerate

   pmode_t           mode;
   logic [DIV_W-1:0] div;
   logic             bnd;

   cpuclk_mode_fsm #(.DIV_W(DIV_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .bnd(bnd),
      .main_stable(main_stable), .sub_stable(sub_stable),
      .mode_wr(mode_wr), .mode_req(mode_req),
      .div_wr(div_wr), .div_val(div_val),
      .sube_wr(sube_wr), .sube_val(sube_val),
      .mode(mode), .div(div), .sub_on(sub_on),
      .pend(req_pend), .err(err_stat)
   );

   cpuclk_divider #(.DIV_W(DIV_W)) u_div (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .mode(mode), .div(div),
      .cpu_en(bnd), .cpu_src(cpu_src), .per_en(per_en)
   );

   cpuclk_tmr_src #(.TMR_DIV(TMR_DIV)) u_tmr (
      .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .sub_on(sub_on),
      .tmr_en(tmr_en)
   );

   assign cpu_en    = bnd;
   assign mode_stat = mode;
   assign div_stat  = div;
   assign main_on   = (mode != MD_LPD);
endmodule

// File: tb/cpuclk_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module cpuclk_pwr_ctrl_bench;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       main_tick = 1'b0, sub_tick = 1'b0;
   logic       main_stable = 1'b1, sub_stable = 1'b0;
   logic       mode_wr = 1'b0, div_wr = 1'b0, sube_wr = 1'b0, sube_val = 1'b0;
   logic [1:0] mode_req = 2'b00, div_val = 2'b00;
   logic       cpu_en, cpu_src, per_en, tmr_en, main_on, sub_on, req_pend, err_stat;
   logic [1:0] mode_stat, div_stat;

   cpuclk_pwr_ctrl u_cpuclk_pwr_ctrl (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .main_stable(main_stable), .sub_stable(sub_stable),
      .mode_wr(mode_wr), .mode_req(mode_req), .div_wr(div_wr), .div_val(div_val),
      .sube_wr(sube_wr), .sube_val(sube_val),
      .cpu_en(cpu_en), .cpu_src(cpu_src), .per_en(per_en), .tmr_en(tmr_en),
      .mode_stat(mode_stat), .div_stat(div_stat), .main_on(main_on),
      .sub_on(sub_on), .req_pend(req_pend), .err_stat(err_stat)
   );

   int checks = 0, errors = 0;
   int main_per = 1, sub_per = 4, mcnt = 0, scnt = 0;

   always @(posedge clk) begin
      #1;
      mcnt = (mcnt + 1 >= main_per) ? 0 : mcnt + 1;
      scnt = (scnt + 1 >= sub_per) ? 0 : scnt + 1;
      main_tick = (mcnt == 0);
      sub_tick  = (scnt == 0);
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_mode(input int m);
      @(negedge clk); mode_wr = 1'b1; mode_req = 2'(m);
      @(negedge clk); mode_wr = 1'b0;
   endtask

   task automatic wr_div(input int d);
      @(negedge clk); div_wr = 1'b1; div_val = 2'(d);
      @(negedge clk); div_wr = 1'b0;
   endtask

   task automatic wr_sube(input logic v);
      @(negedge clk); sube_wr = 1'b1; sube_val = v;
      @(negedge clk); sube_wr = 1'b0;
   endtask

   // cycles between two successive cpu_en pulses
   task automatic gap(output int g);
      do @(negedge clk); while (!cpu_en);
      g = 0;
      do begin @(negedge clk); g++; end while (!cpu_en);
   endtask

   task automatic tgap(output int g);
      do @(negedge clk); while (!tmr_en);
      g = 0;
      do begin @(negedge clk); g++; end while (!tmr_en);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int g, n;
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R1 reset state, R11 encoding
      chk("R1 mode", mode_stat, 1);
      chk("R1 div", div_stat, 2);
      chk("R1 main_on", main_on, 1);
      chk("R1 sub_on", sub_on, 0);
      chk("R1 pend", req_pend, 0);
      chk("R1 err", err_stat, 0);
      gap(g); chk("R3 reset /8", g, 8);
      n = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); n += tmr_en; end
      chk("R10 no tmr with sub off", n, 0);

      // R7 illegal low-power request from medium
      wr_mode(3); cyc(20);
      chk("R7 err set", err_stat, 1);
      chk("R7 mode kept", mode_stat, 1);
      chk("R7 not pending", req_pend, 0);

      // R3 sweep of all divider codes
      for (int c = 0; c < 4; c++) begin
         wr_div(c);
         gap(g);
         chk($sformatf("R3 code %0d", c), g, 1 << (c + 1));
         chk("R3 div_stat", div_stat, c);
      end
      // R3 with slower main tick, code 0
      wr_div(0); gap(g);
      main_per = 3;
      gap(g); gap(g);
      chk("R3 /2 at tick/3", g, 6);
      main_per = 1;
      gap(g); gap(g);

      // R4 old period completes before new ratio
      wr_div(3); gap(g); gap(g);
      chk("R4 /16 active", g, 16);
      do @(negedge clk); while (!cpu_en);
      div_wr = 1'b1; div_val = 2'd0;
      @(negedge clk); div_wr = 1'b0;
      g = 1;
      while (!cpu_en) begin @(negedge clk); g++; end
      chk("R4 old period length", g, 16);
      g = 0;
      do begin @(negedge clk); g++; end while (!cpu_en);
      chk("R4 new period length", g, 2);

      // R2 high speed
      wr_mode(0); cyc(20);
      chk("R11 high code", mode_stat, 0);
      n = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); n += cpu_en; end
      chk("R2 every tick", n, 10);
      wr_mode(1); cyc(10);
      chk("R11 medium code", mode_stat, 1);

      // R6 low-speed request waits for enable and stability
      wr_mode(2); cyc(30);
      chk("R6 pending no enable", mode_stat, 1);
      chk("R6 req_pend", req_pend, 1);
      wr_sube(1'b1); cyc(30);
      chk("R6 pending unstable", mode_stat, 1);
      sub_stable = 1'b1; cyc(12);
      chk("R11 low code", mode_stat, 2);
      chk("R6 pend cleared", req_pend, 0);
      chk("R5 cpu_src", cpu_src, 1);

      // R5 low speed follows sub tick, peripheral keeps main tick
      n = 0;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (cpu_en != sub_tick || per_en != main_tick) n++;
      end
      chk("R5 mismatches", n, 0);

      // R10 timer source
      tgap(g); chk("R10 tmr period", g, 32 * sub_per);
      wr_sube(1'b0); cyc(2);
      chk("R10 clear ignored", sub_on, 1);
      tgap(g); chk("R10 tmr after clear", g, 32 * sub_per);

      // R8 low-power entry forces divide-by-8
      wr_div(3); cyc(10);
      chk("R8 pre div", div_stat, 3);
      wr_mode(3); cyc(10);
      chk("R11 low-power code", mode_stat, 3);
      chk("R8 div forced", div_stat, 2);
      chk("R8 main_on", main_on, 0);
      n = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); n += per_en; end
      chk("R8 per_en off", n, 0);

      // R9 divider locked, exit lands at medium /8
      wr_div(0); cyc(10);
      chk("R9 div write ignored", div_stat, 2);
      main_stable = 1'b0;
      wr_mode(0); cyc(30);
      chk("R6 exit waits main", mode_stat, 3);
      main_stable = 1'b1; cyc(10);
      chk("R9 lands medium", mode_stat, 1);
      chk("R9 div /8", div_stat, 2);
      gap(g); gap(g);
      chk("R9 period 8", g, 8);
      chk("R7 err still set", err_stat, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule